// File: doc/BRIEF.md
# White Balance Gain Loop

This block closes the white balance loop of a camera signal path, once per field. For each field it receives the red, green and blue sums of the picture zone already judged to be white, together with three binary cues: an infrared DC flag, an infrared flicker flag and a bright-scene flag. From the cues it classes the light source. It computes target red and blue gains as green-over-red and green-over-blue ratios with a sequential restoring divider, or substitutes a preset pair when sunlight is judged. It limits the target to a window that depends on the source. It then moves the live gains toward that target by no more than a programmable step per field. The step size sets the loop time constant and keeps colour changes gradual.

Gains are 10-bit unsigned codes in 2.8 fixed point, so code 256 is unity. A field is started by a one-cycle `field_start` pulse. The block ignores further pulses until the gains of the accepted field have been applied.

Top module: `wb_gain_loop`

## Requirements
- R1: When `ir_dc` is 0 at an accepted field start, `src_code` becomes 0 (fluorescent), whatever `ir_flicker` and `bright` are.
- R2: When `ir_dc` is 1 and `ir_flicker` is 0, `src_code` becomes 1 (sunlight), whether or not `bright` is set.
- R3: When `ir_dc` and `ir_flicker` are both 1, `src_code` becomes 3 (sunlight or halogen) if `bright` is 1, and 2 (halogen) if `bright` is 0.
- R4: For source codes other than 1, the red target is floor(G*256/R) and the blue target is floor(G*256/B), each saturated to 1023. A zero divisor gives 1023.
- R5: For source code 1, the targets are the preset pair red 416 and blue 320, and the sums are not used.
- R6: Before stepping, each target is clamped to the window of the source. Red windows: code 0 [192,512], code 1 [256,640], code 2 [128,384], code 3 [128,640]. Blue windows: code 0 [192,512], code 1 [192,448], code 2 [384,960], code 3 [192,960].
- R7: On each applied field, each gain moves toward its clamped target by min(`step_sel`+1, distance). A balance leaning blue therefore raises red gain and lowers blue gain, and a balance leaning red does the reverse.
- R8: `src_code` changes on the clock edge that accepts a field. The gains change on the 25th rising edge after that edge. `upd` is high for exactly the one cycle after that change, and at no other time do the gains move.
- R9: A `field_start` pulse that arrives from the accepting edge up to and including the gain-update edge is ignored. It changes neither the source nor the gains.
- R10: After reset, both gains are 256, `src_code` is 0 and `upd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle pulse: sums and cues of a new field are valid |
| ir_dc | input | 1 | Infrared DC component present |
| ir_flicker | input | 1 | Infrared AC (flicker) component present |
| bright | input | 1 | Scene brighter than the outdoor threshold |
| sum_r | input | 16 | Red sum of the white zone |
| sum_g | input | 16 | Green sum of the white zone |
| sum_b | input | 16 | Blue sum of the white zone |
| step_sel | input | 3 | Step size per field minus one |
| gain_r | output | 10 | Red gain, 2.8 fixed point |
| gain_b | output | 10 | Blue gain, 2.8 fixed point |
| src_code | output | 2 | Judged light source |
| upd | output | 1 | Pulse: gains were just updated |

## Verification
The bench exercises every cue combination of the classifier. A wrong truth table would report halogen or sunlight when no infrared DC component is present. It drives a zero red sum and extreme blue ratios into the halogen window. A divider without saturation or a missing clamp would then push the gain past 384, or leave it below 384 for blue. It checks single steps at the smallest and largest step sizes and a long convergence onto the sunlight preset. An off-by-one in the step limit would overshoot or stall short of the target. A pulse sent into a running field must leave the source and the update cadence alone, and a design that restarts the field would show a late or extra `upd`.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef enum logic [1:0] {
    SRC_FLUOR   = 2'd0,
    SRC_SUN     = 2'd1,
    SRC_HALOGEN = 2'd2,
    SRC_MIXED   = 2'd3
  } light_src_e;

  localparam int SUN_GAIN_R = 416;
  localparam int SUN_GAIN_B = 320;

  // Light-source decision from the three cues.
  function automatic light_src_e classify(input logic dc, input logic flick, input logic brt);
    if (!dc)        return SRC_FLUOR;
    else if (!flick) return SRC_SUN;
    else if (brt)   return SRC_MIXED;
    else            return SRC_HALOGEN;
  endfunction

  // Lower gain limit for a source; blue selects the blue channel.
  function automatic int lim_lo(input light_src_e s, input logic blue);
    case (s)
      SRC_FLUOR:   return 192;
      SRC_SUN:     return blue ? 192 : 256;
      SRC_HALOGEN: return blue ? 384 : 128;
      default:     return blue ? 192 : 128;
    endcase
  endfunction

  // Upper gain limit for a source; blue selects the blue channel.
  function automatic int lim_hi(input light_src_e s, input logic blue);
    case (s)
      SRC_FLUOR:   return 512;
      SRC_SUN:     return blue ? 448 : 640;
      SRC_HALOGEN: return blue ? 960 : 384;
      default:     return blue ? 960 : 640;
    endcase
  endfunction

endpackage

// File: rtl/wb_restoring_div.sv
module wb_restoring_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CW-1:0]    cnt_q;
  logic [DEN_W:0]   shifted;
  logic             fits;
  logic [DEN_W-1:0] rem_nxt;

  // One restoring step: bring in the next dividend bit, subtract if it fits.
  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    fits    = shifted >= {1'b0, den_q};
    rem_nxt = fits ? DEN_W'(shifted - {1'b0, den_q}) : DEN_W'(shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        den_q <= den;
        quo_q <= num;
        cnt_q <= CW'(NUM_W);
      end else if (cnt_q != '0) begin
        rem_q <= rem_nxt;
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CW'(1));
      end
    end
  end

  assign quo = quo_q;
endmodule

// File: rtl/wb_gain_stepper.sv
module wb_gain_stepper #(
  parameter int GAIN_W    = 10,
  parameter int STEP_W    = 3,
  parameter int RESET_VAL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [GAIN_W-1:0] target,
  input  logic [GAIN_W-1:0] lo,
  input  logic [GAIN_W-1:0] hi,
  input  logic [STEP_W-1:0] step_sel,
  output logic [GAIN_W-1:0] tgt_clamped,
  output logic [GAIN_W-1:0] gain
);
  logic [GAIN_W-1:0] gain_q;

  // Move cur toward tgt by at most stp codes.
  function automatic logic [GAIN_W-1:0] move_toward(
    input logic [GAIN_W-1:0] cur,
    input logic [GAIN_W-1:0] tgt,
    input logic [GAIN_W-1:0] stp
  );
    if (tgt > cur) return ((tgt - cur) > stp) ? cur + stp : tgt;
    else           return ((cur - tgt) > stp) ? cur - stp : tgt;
  endfunction

  always_comb begin
    if (target < lo)      tgt_clamped = lo;
    else if (target > hi) tgt_clamped = hi;
    else                  tgt_clamped = target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gain_q <= GAIN_W'(RESET_VAL);
    else if (apply) gain_q <= move_toward(gain_q, tgt_clamped, GAIN_W'(step_sel) + 1'b1);
  end

  assign gain = gain_q;
endmodule

// File: rtl/wb_gain_loop.sv
module wb_gain_loop #(
  parameter int SUM_W  = 16,
  parameter int GAIN_W = 10,
  parameter int FRAC_W = 8,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              ir_dc,
  input  logic              ir_flicker,
  input  logic              bright,
  input  logic [SUM_W-1:0]  sum_r,
  input  logic [SUM_W-1:0]  sum_g,
  input  logic [SUM_W-1:0]  sum_b,
  input  logic [STEP_W-1:0] step_sel,
  output logic [GAIN_W-1:0] gain_r,
  output logic [GAIN_W-1:0] gain_b,
  output logic [1:0]        src_code,
  output logic              upd
);
  import wb_pkg::*;

  localparam int NUM_W      = SUM_W + FRAC_W;
  localparam int RESET_GAIN = 1 << FRAC_W;

  typedef enum logic {PH_IDLE, PH_DIV} phase_e;

  phase_e            phase_q;
  light_src_e        src_q;
  logic [STEP_W-1:0] step_q;
  logic              upd_q;
  logic [1:0]        div_done;
  logic [GAIN_W-1:0] gain_w [2];
  logic [GAIN_W-1:0] tgt_lim [2];

  // Named events for the checker.
  logic accept;
  logic apply_evt;
  assign accept    = field_start && (phase_q == PH_IDLE);
  assign apply_evt = (phase_q == PH_DIV) && div_done[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      src_q   <= SRC_FLUOR;
      step_q  <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= apply_evt;
      if (accept) begin
        phase_q <= PH_DIV;
        src_q   <= classify(ir_dc, ir_flicker, bright);
        step_q  <= step_sel;
      end else if (apply_evt) begin
        phase_q <= PH_IDLE;
      end
    end
  end

  // Channel 0 is red, channel 1 is blue.
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [NUM_W-1:0]  quo;
    logic [GAIN_W-1:0] ratio_sat;
    logic [GAIN_W-1:0] target;
    logic [GAIN_W-1:0] lo;
    logic [GAIN_W-1:0] hi;

    wb_restoring_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(accept),
      .num  ({sum_g, {FRAC_W{1'b0}}}),
      .den  ((ch == 1) ? sum_b : sum_r),
      .quo  (quo),
      .done (div_done[ch])
    );

    assign ratio_sat = (|quo[NUM_W-1:GAIN_W]) ? {GAIN_W{1'b1}} : quo[GAIN_W-1:0];
    assign target    = (src_q == SRC_SUN) ? GAIN_W'((ch == 1) ? SUN_GAIN_B : SUN_GAIN_R)
                                          : ratio_sat;
    assign lo        = GAIN_W'(lim_lo(src_q, ch == 1));
    assign hi        = GAIN_W'(lim_hi(src_q, ch == 1));

    wb_gain_stepper #(.GAIN_W(GAIN_W), .STEP_W(STEP_W), .RESET_VAL(RESET_GAIN)) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .apply      (apply_evt),
      .target     (target),
      .lo         (lo),
      .hi         (hi),
      .step_sel   (step_q),
      .tgt_clamped(tgt_lim[ch]),
      .gain       (gain_w[ch])
    );
  end

  assign gain_r   = gain_w[0];
  assign gain_b   = gain_w[1];
  assign src_code = src_q;
  assign upd      = upd_q;
endmodule

// File: rtl/wb_gain_loop_chk.sv
module wb_gain_loop_chk #(
  parameter int GAIN_W = 10,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_start,
  input logic              ir_dc,
  input logic              ir_flicker,
  input logic              bright,
  input logic [GAIN_W-1:0] gain_r,
  input logic [GAIN_W-1:0] gain_b,
  input logic [1:0]        src_code,
  input logic              upd,
  input logic              accept,
  input logic              apply_evt
);
  localparam int MAX_STEP = 1 << STEP_W;

  p_fluor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ir_dc |=> src_code == 2'd0);

  p_sun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ir_dc && !ir_flicker |=> src_code == 2'd1);

  p_halogen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ir_dc && ir_flicker |=> src_code == (bright ? 2'd3 : 2'd2));

  p_step_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ((gain_r >= $past(gain_r) ? int'(gain_r - $past(gain_r)) : int'($past(gain_r) - gain_r)) <= MAX_STEP)
         && ((gain_b >= $past(gain_b) ? int'(gain_b - $past(gain_b)) : int'($past(gain_b) - gain_b)) <= MAX_STEP));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(gain_r) && $stable(gain_b));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> upd ##1 !upd);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    field_start && !accept |=> $stable(src_code));
endmodule

bind wb_gain_loop wb_gain_loop_chk #(.GAIN_W(GAIN_W), .STEP_W(STEP_W)) u_chk (.*);

// File: tb/wb_gain_loop_bench.sv
`timescale 1ns/1ps
module wb_gain_loop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_start = 1'b0;
  logic        ir_dc = 1'b0, ir_flicker = 1'b0, bright = 1'b0;
  logic [15:0] sum_r = '0, sum_g = '0, sum_b = '0;
  logic [2:0]  step_sel = '0;
  logic [9:0]  gain_r, gain_b;
  logic [1:0]  src_code;
  logic        upd;

  always #2 clk = ~clk;

  wb_gain_loop u_wb_gain_loop (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .ir_dc(ir_dc),
    .ir_flicker(ir_flicker), .bright(bright), .sum_r(sum_r), .sum_g(sum_g),
    .sum_b(sum_b), .step_sel(step_sel), .gain_r(gain_r), .gain_b(gain_b),
    .src_code(src_code), .upd(upd)
  );

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  string cur_req = "R10";

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_gr = 256, m_gb = 256, m_src = 0, m_upd = 0, cd = 0;
  int lat_src, lat_stp, lat_r, lat_g, lat_b;

  function automatic int ref_ratio(int g, int d);
    int q;
    if (d == 0) return 1023;
    q = (g * 256) / d;
    return (q > 1023) ? 1023 : q;
  endfunction

  function automatic int ref_lim(int src, bit blue, bit upper);
    int tbl_lo_r[4] = '{192, 256, 128, 128};
    int tbl_hi_r[4] = '{512, 640, 384, 640};
    int tbl_lo_b[4] = '{192, 192, 384, 192};
    int tbl_hi_b[4] = '{512, 448, 960, 960};
    if (blue) return upper ? tbl_hi_b[src] : tbl_lo_b[src];
    return upper ? tbl_hi_r[src] : tbl_lo_r[src];
  endfunction

  function automatic int ref_next(int cur, int tgt, int src, bit blue, int stp);
    int lo = ref_lim(src, blue, 0);
    int hi = ref_lim(src, blue, 1);
    int t  = (tgt < lo) ? lo : ((tgt > hi) ? hi : tgt);
    int d  = (t > cur) ? t - cur : cur - t;
    if (d > stp) d = stp;
    return (t > cur) ? cur + d : cur - d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gr = 256; m_gb = 256; m_src = 0; m_upd = 0; cd = 0;
    end else begin
      m_upd = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          int tr, tb;
          tr = (lat_src == 1) ? 416 : ref_ratio(lat_g, lat_r);
          tb = (lat_src == 1) ? 320 : ref_ratio(lat_g, lat_b);
          m_gr  = ref_next(m_gr, tr, lat_src, 0, lat_stp);
          m_gb  = ref_next(m_gb, tb, lat_src, 1, lat_stp);
          m_upd = 1;
        end
      end else if (field_start) begin
        if (!ir_dc)           lat_src = 0;
        else if (!ir_flicker) lat_src = 1;
        else                  lat_src = bright ? 3 : 2;
        m_src   = lat_src;
        lat_stp = int'(step_sel) + 1;
        lat_r = sum_r; lat_g = sum_g; lat_b = sum_b;
        cd = 25;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "gain_r", int'(gain_r), m_gr);
      check(cur_req, "gain_b", int'(gain_b), m_gb);
      check(cur_req, "src_code", int'(src_code), m_src);
      check("R8", "upd", int'(upd), m_upd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_field(input bit dc, input bit fl, input bit br,
                           input int r, input int g, input int b, input int stp);
    @(negedge clk);
    ir_dc = dc; ir_flicker = fl; bright = br;
    sum_r = 16'(r); sum_g = 16'(g); sum_b = 16'(b); step_sel = 3'(stp);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    repeat (28) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset gain_r", int'(gain_r), 256);
    check("R10", "reset gain_b", int'(gain_b), 256);
    check("R10", "reset src_code", int'(src_code), 0);
    check("R10", "reset upd", int'(upd), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 + R4 + R7: fluorescent, step 3 then 8
    cur_req = "R1";
    run_field(0, 1, 1, 1000, 1200, 1500, 2);
    check("R1", "src flicker+bright", int'(src_code), 0);
    check("R7", "gain_r single step", int'(gain_r), 259);
    check("R7", "gain_b single step", int'(gain_b), 253);
    cur_req = "R4";
    run_field(0, 0, 1, 1000, 1200, 1500, 7);
    check("R1", "src bright only", int'(src_code), 0);
    check("R4", "gain_r step to ratio 307", int'(gain_r), 267);
    check("R4", "gain_b step to ratio 204", int'(gain_b), 245);
    run_field(0, 1, 0, 1000, 1200, 1500, 0);
    check("R1", "src flicker only", int'(src_code), 0);
    check("R7", "gain_r minimum step", int'(gain_r), 268);

    // R2 + R5: sunlight preset, converge with step 8
    cur_req = "R5";
    run_field(1, 0, 0, 5, 60000, 7, 7);
    check("R2", "src dark sunlight", int'(src_code), 1);
    for (int i = 0; i < 19; i++) run_field(1, 0, 1, 9, 1, 9, 7);
    check("R2", "src bright sunlight", int'(src_code), 1);
    check("R5", "gain_r preset", int'(gain_r), 416);
    check("R5", "gain_b preset", int'(gain_b), 320);

    // R3 + R6: halogen, zero red divisor, blue below window
    cur_req = "R6";
    for (int i = 0; i < 8; i++) run_field(1, 1, 0, 0, 1000, 4000, 7);
    check("R3", "src halogen", int'(src_code), 2);
    check("R6", "gain_r clamped to 384", int'(gain_r), 384);
    check("R6", "gain_b clamped to 384", int'(gain_b), 384);

    // R3: mixed source, ratio inside wide window
    cur_req = "R3";
    run_field(1, 1, 1, 500, 1000, 2000, 7);
    check("R3", "src mixed", int'(src_code), 3);
    check("R7", "gain_r leaning blue rises", int'(gain_r), 392);
    check("R7", "gain_b leaning blue falls", int'(gain_b), 376);

    // R9: pulse during a running field is ignored
    cur_req = "R9";
    @(negedge clk);
    ir_dc = 1; ir_flicker = 0; bright = 0; step_sel = 3'd7;
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    repeat (5) @(negedge clk);
    ir_dc = 0; field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    check("R9", "src during busy", int'(src_code), 1);
    repeat (30) @(negedge clk);
    check("R9", "src after busy", int'(src_code), 1);
    check("R9", "gain_r one step toward preset", int'(gain_r), 400);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule